// File: doc/BRIEF.md
# Interrupt Vector Catch Address Matcher

This block watches the instruction fetch stream. It raises a one-cycle debug event when a fetch reaches the point where an IRQ or FIQ handler starts. There are two kinds of catch address. A local catch address belongs to the current security bank. A monitor catch address is taken from a single monitor base.

Each bank has its own vector-enable bit and its own exception base. When that bank's vector-enable bit is clear, the local catch addresses are fixed offsets from the bank's base. When the bit is set, the local catch addresses are the handler addresses most recently delivered by the interrupt controller. These addresses are captured per bank and per interrupt type. Until a captured address exists, no local event is produced.

The interrupt controller delivers handler addresses over a valid/ready channel. A transfer takes place on a rising clock edge where both `vec_valid` and `vec_ready` are high. The supplier must hold `vec_valid`, `vec_is_fiq` and `vec_addr` steady until that edge. `vec_ready` is low during reset and in the first cycle after it, and high from then on. The block never applies back-pressure once it is running. Fetch addresses are virtual addresses, compared as given, with no translation.

Top module: `vcatch_matcher`

## Requirements
- R1: The vector-enable bit and exception base used for local catch come from the Secure bank when `sec_state` is 1 and from the Non-secure bank when it is 0. Captured handler addresses are also kept per bank, and only the current bank's captures are matched.
- R2: With the active vector-enable bit at 0, the local IRQ catch address is base + 0x18 and the local FIQ catch address is base + 0x1C.
- R3: With the active vector-enable bit at 1, the local catch address for each interrupt type is the last handler address captured for that type in the current bank. `vec_is_fiq` = 1 marks a FIQ address and 0 marks an IRQ address, and the capture lands in the bank given by `sec_state` at the transfer edge.
- R4: The monitor IRQ catch address is `mon_base` + 0x18 and the monitor FIQ catch address is `mon_base` + 0x1C. Both apply in either security state and regardless of the vector-enable bits.
- R5: While the active vector-enable bit is 1, a type with no capture since reset or since the last rising edge of that bank's vector-enable bit produces no local event.
- R6: A handler address captured while its local catch enable was off is still matched once that enable is turned on. This is the default policy, selected by parameter `LATE_MATCH` = 1.
- R7: While the active vector-enable bit is 1, an interrupt type flagged as taken to monitor (`irq_to_mon` / `fiq_to_mon`) produces no local event.
- R8: `dbg_event` is high in the cycle after a fetch strobe whose address matches an enabled, live catch address. It is high for one cycle per such fetch, and it stays low after a cycle without `fetch_valid`.
- R9: `vec_ready` is 0 in reset and rises one cycle after reset is released.
- R10: The bits of `catch_en` enable the catches: bit 0 local IRQ, bit 1 local FIQ, bit 2 monitor IRQ, bit 3 monitor FIQ. A matching address whose bit is 0 produces no event.
- R11: Reset clears all captured addresses and their valid flags, and holds `dbg_event` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_state | input | 1 | 1 = Secure, 0 = Non-secure |
| s_vec_en | input | 1 | Secure vector-enable bit |
| s_base | input | AW | Secure exception base |
| ns_vec_en | input | 1 | Non-secure vector-enable bit |
| ns_base | input | AW | Non-secure exception base |
| mon_base | input | AW | Monitor exception base |
| irq_to_mon | input | 1 | IRQ is taken to monitor |
| fiq_to_mon | input | 1 | FIQ is taken to monitor |
| catch_en | input | 4 | Catch enables (see R10) |
| vec_valid | input | 1 | Handler address offered |
| vec_ready | output | 1 | Handler address accepted |
| vec_is_fiq | input | 1 | Offered address is for FIQ |
| vec_addr | input | AW | Offered handler address |
| fetch_valid | input | 1 | Fetch address strobe |
| fetch_va | input | AW | Fetch virtual address |
| dbg_event | output | 1 | Vector catch event pulse |

## Verification
The fetch address is swept across several patterns. Base+0x18 and base+0x1C in each bank show whether the bank and the type offset are chosen correctly. The other bank's addresses expose a wrong bank choice. Monitor offsets are tried with the local bits cleared, to show that the two catch sources are independent. With vectoring on, fetches hit a captured address, the stale fixed address, and an address from before a vector-enable toggle. These separate correct capture from missing invalidation. Fetches are also issued with monitor routing set and with enables that were turned on late, and back-to-back cycles check that the event lasts one cycle.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  localparam int unsigned NBANK   = 2;
  localparam int unsigned NTYPE   = 2;
  localparam int unsigned CE_LIRQ = 0;
  localparam int unsigned CE_LFIQ = 1;
  localparam int unsigned CE_MIRQ = 2;
  localparam int unsigned CE_MFIQ = 3;
  localparam int unsigned NCATCH  = 4;
  typedef enum logic {BANK_NS = 1'b0, BANK_S = 1'b1} bank_e;
  typedef enum logic {TYPE_IRQ = 1'b0, TYPE_FIQ = 1'b1} itype_e;
endpackage

// File: rtl/vcm_vec_slot.sv
module vcm_vec_slot #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_armed,
  output logic [AW-1:0] addr,
  output logic          valid,
  output logic          armed
);
  // A write wins over a clear in the same cycle: it is the newer vector.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      valid <= 1'b0;
      armed <= 1'b0;
    end else if (wr) begin
      addr  <= wr_addr;
      valid <= 1'b1;
      armed <= wr_armed;
    end else if (clr) begin
      valid <= 1'b0;
      armed <= 1'b0;
    end
  end
endmodule

// File: rtl/vcm_local_sel.sv
module vcm_local_sel #(
  parameter int unsigned AW         = 32,
  parameter logic [AW-1:0] IRQ_OFS  = 'h18,
  parameter logic [AW-1:0] FIQ_OFS  = 'h1C,
  parameter bit          LATE_MATCH = 1'b1
) (
  input  logic                          ve,
  input  logic [AW-1:0]                 base,
  input  logic [vcm_pkg::NTYPE-1:0]          slot_valid,
  input  logic [vcm_pkg::NTYPE-1:0]          slot_armed,
  input  logic [vcm_pkg::NTYPE-1:0][AW-1:0]  slot_addr,
  input  logic [vcm_pkg::NTYPE-1:0]          to_mon,
  output logic [vcm_pkg::NTYPE-1:0][AW-1:0]  loc_addr,
  output logic [vcm_pkg::NTYPE-1:0]          loc_live
);
  for (genvar t = 0; t < vcm_pkg::NTYPE; t++) begin : g_type
    localparam logic [AW-1:0] OFS = (t == vcm_pkg::TYPE_FIQ) ? FIQ_OFS : IRQ_OFS;
    always_comb begin
      if (!ve) begin
        loc_addr[t] = base + OFS;
        loc_live[t] = 1'b1;
      end else begin
        loc_addr[t] = slot_addr[t];
        loc_live[t] = slot_valid[t] & ~to_mon[t] & (LATE_MATCH | slot_armed[t]);
      end
    end
  end
endmodule

// File: rtl/vcm_match.sv
module vcm_match #(
  parameter int unsigned AW = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fetch_valid,
  input  logic [AW-1:0]               fetch_va,
  input  logic [vcm_pkg::NCATCH-1:0]          enable,
  input  logic [vcm_pkg::NCATCH-1:0]          live,
  input  logic [vcm_pkg::NCATCH-1:0][AW-1:0]  cand,
  output logic                        hit_q
);
  logic [vcm_pkg::NCATCH-1:0] hit;
  for (genvar c = 0; c < vcm_pkg::NCATCH; c++) begin : g_cmp
    assign hit[c] = enable[c] & live[c] & (fetch_va == cand[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= fetch_valid & (|hit);
  end
endmodule

// File: rtl/vcatch_matcher.sv
module vcatch_matcher #(
  parameter int unsigned AW         = 32,
  parameter logic [AW-1:0] IRQ_OFS  = 'h18,
  parameter logic [AW-1:0] FIQ_OFS  = 'h1C,
  parameter bit          LATE_MATCH = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_state,
  input  logic          s_vec_en,
  input  logic [AW-1:0] s_base,
  input  logic          ns_vec_en,
  input  logic [AW-1:0] ns_base,
  input  logic [AW-1:0] mon_base,
  input  logic          irq_to_mon,
  input  logic          fiq_to_mon,
  input  logic [3:0]    catch_en,
  input  logic          vec_valid,
  output logic          vec_ready,
  input  logic          vec_is_fiq,
  input  logic [AW-1:0] vec_addr,
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_va,
  output logic          dbg_event
);
  import vcm_pkg::*;

  logic [NBANK-1:0]          ve, ve_q, ve_rise;
  logic [NBANK-1:0][AW-1:0]  base_b;
  logic [NBANK-1:0][NTYPE-1:0]          sv, sa;
  logic [NBANK-1:0][NTYPE-1:0][AW-1:0]  saddr;
  logic                      take;

  assign ve[BANK_NS]     = ns_vec_en;
  assign ve[BANK_S]      = s_vec_en;
  assign base_b[BANK_NS] = ns_base;
  assign base_b[BANK_S]  = s_base;
  assign ve_rise         = ve & ~ve_q;
  assign take            = vec_valid & vec_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ve_q      <= '0;
      vec_ready <= 1'b0;
    end else begin
      ve_q      <= ve;
      vec_ready <= 1'b1;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar t = 0; t < NTYPE; t++) begin : g_slot
      vcm_vec_slot #(.AW(AW)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (ve_rise[b]),
        .wr       (take && (sec_state == b[0]) && (vec_is_fiq == t[0])),
        .wr_addr  (vec_addr),
        .wr_armed (catch_en[t]),
        .addr     (saddr[b][t]),
        .valid    (sv[b][t]),
        .armed    (sa[b][t])
      );
    end
  end

  logic [NTYPE-1:0][AW-1:0] loc_addr;
  logic [NTYPE-1:0]         loc_live;

  vcm_local_sel #(
    .AW(AW), .IRQ_OFS(IRQ_OFS), .FIQ_OFS(FIQ_OFS), .LATE_MATCH(LATE_MATCH)
  ) u_sel (
    .ve         (ve[sec_state]),
    .base       (base_b[sec_state]),
    .slot_valid (sv[sec_state]),
    .slot_armed (sa[sec_state]),
    .slot_addr  (saddr[sec_state]),
    .to_mon     ({fiq_to_mon, irq_to_mon}),
    .loc_addr   (loc_addr),
    .loc_live   (loc_live)
  );

  logic [NCATCH-1:0][AW-1:0] cand;
  logic [NCATCH-1:0]         live;
  assign cand[CE_LIRQ] = loc_addr[TYPE_IRQ];
  assign cand[CE_LFIQ] = loc_addr[TYPE_FIQ];
  assign cand[CE_MIRQ] = mon_base + IRQ_OFS;
  assign cand[CE_MFIQ] = mon_base + FIQ_OFS;
  assign live          = {2'b11, loc_live[TYPE_FIQ], loc_live[TYPE_IRQ]};

  vcm_match #(.AW(AW)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_va    (fetch_va),
    .enable      (catch_en),
    .live        (live),
    .cand        (cand),
    .hit_q       (dbg_event)
  );
endmodule

// File: rtl/vcm_checker.sv
module vcm_checker #(
  parameter int unsigned AW        = 32,
  parameter logic [AW-1:0] IRQ_OFS = 'h18,
  parameter logic [AW-1:0] FIQ_OFS = 'h1C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sec_state,
  input logic          s_vec_en,
  input logic [AW-1:0] s_base,
  input logic          ns_vec_en,
  input logic [AW-1:0] ns_base,
  input logic [AW-1:0] mon_base,
  input logic [3:0]    catch_en,
  input logic          vec_ready,
  input logic          fetch_valid,
  input logic [AW-1:0] fetch_va,
  input logic          dbg_event
);
  logic          act_ve;
  logic [AW-1:0] act_base;
  assign act_ve   = sec_state ? s_vec_en : ns_vec_en;
  assign act_base = sec_state ? s_base : ns_base;

  AST_EVENT_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(fetch_valid)); // R8
  AST_NO_EVENT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && catch_en == 4'b0000) |=> !dbg_event); // R10
  AST_MON_IRQ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && catch_en[2] && fetch_va == mon_base + IRQ_OFS) |=> dbg_event); // R4
  AST_MON_FIQ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && catch_en[3] && fetch_va == mon_base + FIQ_OFS) |=> dbg_event); // R4
  AST_FIXED_IRQ_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && catch_en[0] && !act_ve && fetch_va == act_base + IRQ_OFS) |=> dbg_event); // R2
  AST_READY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> vec_ready); // R9
endmodule

bind vcatch_matcher vcm_checker #(.AW(AW), .IRQ_OFS(IRQ_OFS), .FIQ_OFS(FIQ_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_state(sec_state), .s_vec_en(s_vec_en),
  .s_base(s_base), .ns_vec_en(ns_vec_en), .ns_base(ns_base), .mon_base(mon_base),
  .catch_en(catch_en), .vec_ready(vec_ready), .fetch_valid(fetch_valid),
  .fetch_va(fetch_va), .dbg_event(dbg_event)
);

// File: tb/sim_vcatch_matcher.sv
`timescale 1ns/1ps
module sim_vcatch_matcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_state = 1'b0, s_vec_en = 1'b0, ns_vec_en = 1'b0;
  logic [31:0] s_base = '0, ns_base = '0, mon_base = '0;
  logic        irq_to_mon = 1'b0, fiq_to_mon = 1'b0;
  logic [3:0]  catch_en = '0;
  logic        vec_valid = 1'b0, vec_is_fiq = 1'b0;
  logic [31:0] vec_addr = '0;
  logic        vec_ready;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_va = '0;
  logic        dbg_event;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  vcatch_matcher u0 (
    .clk(clk), .rst_n(rst_n), .sec_state(sec_state), .s_vec_en(s_vec_en),
    .s_base(s_base), .ns_vec_en(ns_vec_en), .ns_base(ns_base), .mon_base(mon_base),
    .irq_to_mon(irq_to_mon), .fiq_to_mon(fiq_to_mon), .catch_en(catch_en),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_is_fiq(vec_is_fiq),
    .vec_addr(vec_addr), .fetch_valid(fetch_valid), .fetch_va(fetch_va),
    .dbg_event(dbg_event)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic fetch(input string req, input logic [31:0] va, input logic exp);
    @(negedge clk); fetch_valid = 1'b1; fetch_va = va;
    @(negedge clk); fetch_valid = 1'b0;
    chk(req, dbg_event, exp);
  endtask

  task automatic supply(input logic fiq, input logic [31:0] a);
    @(negedge clk); vec_valid = 1'b1; vec_is_fiq = fiq; vec_addr = a;
    @(negedge clk); vec_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk("R9 ready low in reset", vec_ready, 1'b0);
    chk("R11 event low in reset", dbg_event, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); chk("R9 ready after reset", vec_ready, 1'b1);
  endtask

  task automatic t_fixed();
    ns_base = 32'h1000; catch_en = 4'b0001;
    fetch("R2 ns irq base+0x18", 32'h1018, 1'b1);
    fetch("R10 fiq enable off", 32'h101C, 1'b0);
    catch_en = 4'b0011;
    fetch("R2 ns fiq base+0x1C", 32'h101C, 1'b1);
  endtask

  task automatic t_bank();
    sec_state = 1'b1; s_base = 32'h2000;
    fetch("R1 ns addr in secure", 32'h1018, 1'b0);
    fetch("R1 secure irq", 32'h2018, 1'b1);
    sec_state = 1'b0;
  endtask

  task automatic t_monitor();
    mon_base = 32'h3000; catch_en = 4'b1100;
    fetch("R4 mon irq", 32'h3018, 1'b1);
    fetch("R4 mon fiq", 32'h301C, 1'b1);
    ns_vec_en = 1'b1;
    fetch("R4 mon irq with vectoring", 32'h3018, 1'b1);
    ns_vec_en = 1'b0;
    catch_en = 4'b0011;
    fetch("R10 mon disabled", 32'h3018, 1'b0);
  endtask

  task automatic t_vectored();
    ns_vec_en = 1'b1;
    fetch("R5 no capture yet", 32'h1018, 1'b0);
    supply(1'b0, 32'h8000);
    fetch("R3 captured irq", 32'h8000, 1'b1);
    fetch("R5 fiq still empty", 32'h101C, 1'b0);
    supply(1'b1, 32'h9000);
    fetch("R3 captured fiq", 32'h9000, 1'b1);
    sec_state = 1'b1; s_vec_en = 1'b1;
    fetch("R1 other bank capture", 32'h8000, 1'b0);
    sec_state = 1'b0;
    irq_to_mon = 1'b1;
    fetch("R7 irq to monitor", 32'h8000, 1'b0);
    fetch("R7 fiq unaffected", 32'h9000, 1'b1);
    irq_to_mon = 1'b0;
    @(negedge clk); ns_vec_en = 1'b0;
    @(negedge clk); ns_vec_en = 1'b1;
    fetch("R5 cleared by ve rise", 32'h8000, 1'b0);
  endtask

  task automatic t_late();
    catch_en = 4'b0000;
    supply(1'b0, 32'hA000);
    catch_en = 4'b0001;
    fetch("R6 late enable matches", 32'hA000, 1'b1);
    @(negedge clk);
    chk("R8 single cycle", dbg_event, 1'b0);
    fetch_va = 32'hA000;
    @(negedge clk);
    chk("R8 no strobe no event", dbg_event, 1'b0);
  endtask

  task automatic t_reset_clear();
    do_reset();
    fetch("R11 capture cleared", 32'hA000, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 event low in reset", dbg_event, 1'b0);
    rst_n = 1'b1;
    @(negedge clk); chk("R9 ready after reset", vec_ready, 1'b1);
    t_fixed();
    t_bank();
    t_monitor();
    t_vectored();
    t_late();
    t_reset_clear();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule